// File: doc/BRIEF.md
# Runtime-Configurable Serial Transmitter and Receiver

This block is an asynchronous serial port with a transmit half and a receive half that share one 31-bit setup word. Software or surrounding logic can change the word at any time. It sets the bit period in system clocks, the character length (5 to 8 bits), one or two stop bits, and the parity scheme. Parity can be off, fixed at mark or space, or computed as even or odd. The transmitter takes a byte through a valid/ready handshake and sends it least significant bit first. The receiver detects a start bit, samples each bit near its centre, and reports the character together with parity and framing error flags.

The line idles high. A frame is one low start bit, then the data bits, then the parity bit if enabled, then the stop bits (high). The transmitter captures the setup word only when it accepts a byte. The receiver captures it only while it waits for a start bit. A change written in the middle of a character therefore applies from the next character.

Top module: `cfg_uart`

## Requirements
- R1: After reset, and whenever the transmitter is idle, `txLine` is high and `txReady` is high. `rxValid` is low after reset.
- R2: Setup bits 23:0 give the number of clocks per serial bit. Every transmitted bit lasts exactly that many clocks. The low start bit begins in the cycle after the handshake edge.
- R3: The data bits follow the start bit, least significant bit first. Setup bits 29:28 set their number: 00 gives 8, 01 gives 7, 10 gives 6, 11 gives 5. Unsent upper bits of `txData` are ignored.
- R4: Setup bit 26 set adds one parity bit after the data. If bit 25 is set, the parity bit equals bit 24. If bit 25 is clear, bit 24 set selects even parity (the bit is the XOR of the data bits) and clear selects odd parity (the inverse).
- R5: Setup bit 27 set sends two high stop bits; clear sends one. `txReady` is low in the last cycle of the frame and high in the cycle after it, which is (frame bits × bit period) cycles after the handshake edge.
- R6: A byte is accepted on a clock edge where `txValid` and `txReady` are both high. `txReady` stays low for the rest of the frame.
- R7: For every character length, stop setting and parity mode, the receiver returns the transmitted byte on `rxData`, right-aligned with the unused upper bits zero. It marks the byte with a one-cycle `rxValid` pulse and no error flags.
- R8: `rxParityErr` is set with `rxValid` when the received parity bit differs from the value R4 requires. It is never set when parity is disabled.
- R9: `rxFrameErr` is set with `rxValid` when the line is low at the sample point of any stop bit, including the second of two.
- R10: A low pulse that is gone by the half-bit check after a falling edge produces no character. The receiver then accepts the next valid frame.
- R11: A setup change written while a character is in flight does not alter that character on either side. The next character uses the new setup.
- R12: Setup bit 30 has no effect on the line waveform or the received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| setupWord | input | 31 | Packed line setup: divisor, length, stops, parity |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Byte on txData is offered |
| txReady | output | 1 | Transmitter idle and able to accept |
| txLine | output | 1 | Serial output, idles high |
| rxLine | input | 1 | Serial input, asynchronous |
| rxData | output | 8 | Received character, right-aligned |
| rxValid | output | 1 | One-cycle pulse marking a received character |
| rxParityErr | output | 1 | Parity mismatch on the marked character |
| rxFrameErr | output | 1 | Low stop-bit sample on the marked character |

## Verification
Every transmit result has a fixed due cycle. The start bit appears in the cycle after the accepting edge, bit k covers cycles k·D through k·D+D−1 for a period of D clocks, and `txReady` rises at cycle (frame bits)·D. The bench therefore compares `txLine` on every falling clock edge of the frame against a waveform it builds arithmetically from the byte and setup fields. A receive result is due at most a few cycles after the centre of the last stop bit, allowing for two synchronizer stages and the edge detector. The bench records every `rxValid` pulse and reads the record only after 2·D+4 idle cycles past the end of the frame. The sweep covers all four lengths, both stop settings and all five parity modes. Further cases drive the receive line directly to inject parity errors, framing errors and false starts.

// File: rtl/cfg_uart_pkg.sv
package cfg_uart_pkg;

  // Width of the bit-period field in the setup word (fixed by the word layout)
  localparam int DivW = 24;
  localparam int ByteW = 8;
  localparam int LenW = 4;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} phaseT;

  typedef struct packed {
    logic [DivW-1:0] div;
    logic [LenW-1:0] len;
    logic twoStop;
    logic parEn;
    logic parFixed;
    logic parSel;
  } lineCfgT;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic txParity;
    logic txStop;
    logic rxCfgLoad;
    logic rxClear;
    logic rxShift;
    logic rxParity;
    logic rxStop;
    logic rxDone;
  } strobeT;

  function automatic lineCfgT decodeSetup(input logic [29:0] w);
    lineCfgT c;
    c.div = w[DivW-1:0];
    c.parSel = w[24];
    c.parFixed = w[25];
    c.parEn = w[26];
    c.twoStop = w[27];
    c.len = LenW'(ByteW) - {2'b00, w[29:28]};
    return c;
  endfunction

endpackage

// File: rtl/cfg_uart_dp.sv
module cfg_uart_dp
  import cfg_uart_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  strobeT strb,
  input  logic [30:0] setupWord,
  input  logic [ByteW-1:0] txData,
  input  logic rxLine,
  output lineCfgT txCfg,
  output lineCfgT rxCfg,
  output logic txLine,
  output logic rxBit,
  output logic rxFall,
  output logic [ByteW-1:0] rxData,
  output logic rxValid,
  output logic rxParityErr,
  output logic rxFrameErr
);

  logic unusedFlowCtl;
  assign unusedFlowCtl = setupWord[30];

  lineCfgT txCfgQ, rxCfgQ;
  logic [ByteW-1:0] txShreg, rxShreg;
  logic txAcc, rxAcc, txLineQ;
  logic [1:0] rxSync;
  logic rxPrev, rxPerr, rxFerr;
  logic txParBit, rxExpPar;

  assign txParBit = txCfgQ.parFixed ? txCfgQ.parSel : (txCfgQ.parSel ? txAcc : ~txAcc);
  assign rxExpPar = rxCfgQ.parFixed ? rxCfgQ.parSel : (rxCfgQ.parSel ? rxAcc : ~rxAcc);

  // transmit shifter and line register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCfgQ <= '0;
      txShreg <= '0;
      txAcc <= 1'b0;
      txLineQ <= 1'b1;
    end else if (strb.txLoad) begin
      txCfgQ <= decodeSetup(setupWord[29:0]);
      txShreg <= txData;
      txAcc <= 1'b0;
      txLineQ <= 1'b0;
    end else if (strb.txShift) begin
      txLineQ <= txShreg[0];
      txAcc <= txAcc ^ txShreg[0];
      txShreg <= {1'b0, txShreg[ByteW-1:1]};
    end else if (strb.txParity) begin
      txLineQ <= txParBit;
    end else if (strb.txStop) begin
      txLineQ <= 1'b1;
    end
  end

  // receive synchronizer, edge detect, shifter and result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync <= 2'b11;
      rxPrev <= 1'b1;
      rxCfgQ <= '0;
      rxShreg <= '0;
      rxAcc <= 1'b0;
      rxPerr <= 1'b0;
      rxFerr <= 1'b0;
      rxData <= '0;
      rxValid <= 1'b0;
      rxParityErr <= 1'b0;
      rxFrameErr <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxLine};
      rxPrev <= rxSync[1];
      rxValid <= strb.rxDone;
      if (strb.rxCfgLoad) rxCfgQ <= decodeSetup(setupWord[29:0]);
      if (strb.rxClear) begin
        rxShreg <= '0;
        rxAcc <= 1'b0;
        rxPerr <= 1'b0;
        rxFerr <= 1'b0;
      end
      if (strb.rxShift) begin
        rxShreg <= {rxSync[1], rxShreg[ByteW-1:1]};
        rxAcc <= rxAcc ^ rxSync[1];
      end
      if (strb.rxParity) rxPerr <= (rxSync[1] != rxExpPar);
      if (strb.rxStop && !rxSync[1]) rxFerr <= 1'b1;
      if (strb.rxDone) begin
        rxData <= rxShreg >> (LenW'(ByteW) - rxCfgQ.len);
        rxParityErr <= rxPerr;
        rxFrameErr <= rxFerr | ~rxSync[1];
      end
    end
  end

  assign txCfg = txCfgQ;
  assign rxCfg = rxCfgQ;
  assign txLine = txLineQ;
  assign rxBit = rxSync[1];
  assign rxFall = rxPrev & ~rxSync[1];

  // R5
  stop_before_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |-> txLineQ);

endmodule

// File: rtl/cfg_uart_ctrl.sv
module cfg_uart_ctrl
  import cfg_uart_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic txValid,
  input  logic [DivW-1:0] txDiv,
  input  logic [LenW-1:0] txLen,
  input  logic txTwoStop,
  input  logic txParEn,
  input  logic [DivW-1:0] rxDiv,
  input  logic [LenW-1:0] rxLen,
  input  logic rxTwoStop,
  input  logic rxParEn,
  input  logic rxBit,
  input  logic rxFall,
  output logic txReady,
  output strobeT strb
);

  localparam int CntW = DivW + 1;

  phaseT txPh, rxPh;
  logic [DivW-1:0] txCnt, rxCnt;
  logic [LenW-1:0] txIdx, rxIdx;
  logic txBitEnd, rxBitEnd, rxHalfEnd;
  logic txLastData, rxLastData, txLastStop, rxLastStop, rxCntClr;

  assign txBitEnd = ({1'b0, txCnt} + CntW'(1)) >= {1'b0, txDiv};
  assign rxBitEnd = ({1'b0, rxCnt} + CntW'(1)) >= {1'b0, rxDiv};
  assign rxHalfEnd = ({1'b0, rxCnt} + CntW'(1)) >= {2'b00, rxDiv[DivW-1:1]};
  assign txLastData = txIdx == LenW'(txLen - 4'd1);
  assign rxLastData = rxIdx == LenW'(rxLen - 4'd1);
  assign txLastStop = !txTwoStop || txIdx == 4'd1;
  assign rxLastStop = !rxTwoStop || rxIdx == 4'd1;
  assign txReady = txPh == S_IDLE;

  always_comb begin
    strb = '0;
    strb.txLoad = (txPh == S_IDLE) && txValid;
    if (txBitEnd) begin
      case (txPh)
        S_START: strb.txShift = 1'b1;
        S_DATA: begin
          if (!txLastData) strb.txShift = 1'b1;
          else if (txParEn) strb.txParity = 1'b1;
          else strb.txStop = 1'b1;
        end
        S_PAR: strb.txStop = 1'b1;
        default: ;
      endcase
    end
    strb.rxCfgLoad = rxPh == S_IDLE;
    strb.rxClear = (rxPh == S_IDLE) && rxFall;
    if (rxBitEnd) begin
      case (rxPh)
        S_DATA: strb.rxShift = 1'b1;
        S_PAR: strb.rxParity = 1'b1;
        S_STOP: begin
          strb.rxStop = 1'b1;
          strb.rxDone = rxLastStop;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPh <= S_IDLE;
      txCnt <= '0;
      txIdx <= '0;
    end else begin
      txCnt <= (txPh == S_IDLE || txBitEnd) ? '0 : txCnt + 1'b1;
      case (txPh)
        S_IDLE: if (txValid) txPh <= S_START;
        S_START: if (txBitEnd) begin txPh <= S_DATA; txIdx <= '0; end
        S_DATA: if (txBitEnd) begin
          if (txLastData) begin
            txPh <= txParEn ? S_PAR : S_STOP;
            txIdx <= '0;
          end else txIdx <= txIdx + 1'b1;
        end
        S_PAR: if (txBitEnd) begin txPh <= S_STOP; txIdx <= '0; end
        S_STOP: if (txBitEnd) begin
          if (txLastStop) txPh <= S_IDLE;
          else txIdx <= txIdx + 1'b1;
        end
        default: txPh <= S_IDLE;
      endcase
    end
  end

  assign rxCntClr = (rxPh == S_IDLE) || ((rxPh == S_START) ? rxHalfEnd : rxBitEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPh <= S_IDLE;
      rxCnt <= '0;
      rxIdx <= '0;
    end else begin
      rxCnt <= rxCntClr ? '0 : rxCnt + 1'b1;
      case (rxPh)
        S_IDLE: if (rxFall) rxPh <= S_START;
        S_START: if (rxHalfEnd) begin
          rxPh <= rxBit ? S_IDLE : S_DATA;
          rxIdx <= '0;
        end
        S_DATA: if (rxBitEnd) begin
          if (rxLastData) begin
            rxPh <= rxParEn ? S_PAR : S_STOP;
            rxIdx <= '0;
          end else rxIdx <= rxIdx + 1'b1;
        end
        S_PAR: if (rxBitEnd) begin rxPh <= S_STOP; rxIdx <= '0; end
        S_STOP: if (rxBitEnd) begin
          if (rxLastStop) rxPh <= S_IDLE;
          else rxIdx <= rxIdx + 1'b1;
        end
        default: rxPh <= S_IDLE;
      endcase
    end
  end

  // R10
  no_sample_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxPh == S_IDLE) |=> !strb.rxShift && !strb.rxDone);

endmodule

// File: rtl/cfg_uart.sv
module cfg_uart
  import cfg_uart_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic [30:0] setupWord,
  input  logic [7:0] txData,
  input  logic txValid,
  output logic txReady,
  output logic txLine,
  input  logic rxLine,
  output logic [7:0] rxData,
  output logic rxValid,
  output logic rxParityErr,
  output logic rxFrameErr
);

  lineCfgT txCfg, rxCfg;
  strobeT strb;
  logic rxBit, rxFall;

  cfg_uart_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .txValid(txValid),
    .txDiv(txCfg.div), .txLen(txCfg.len), .txTwoStop(txCfg.twoStop), .txParEn(txCfg.parEn),
    .rxDiv(rxCfg.div), .rxLen(rxCfg.len), .rxTwoStop(rxCfg.twoStop), .rxParEn(rxCfg.parEn),
    .rxBit(rxBit), .rxFall(rxFall), .txReady(txReady), .strb(strb)
  );

  cfg_uart_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .setupWord(setupWord), .txData(txData),
    .rxLine(rxLine), .txCfg(txCfg), .rxCfg(rxCfg), .txLine(txLine), .rxBit(rxBit),
    .rxFall(rxFall), .rxData(rxData), .rxValid(rxValid), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr)
  );

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  // R6
  accept_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady |=> !txLine && !txReady);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R8
  no_parity_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxCfg.parEn |-> !rxParityErr);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txReady |=> $stable(txCfg));

endmodule

// File: tb/test_cfg_uart.sv
`timescale 1ns/1ps
module test_cfg_uart;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [30:0] setupWord = '0;
  logic [7:0] txData = '0;
  logic txValid = 1'b0;
  logic txReady, txLine;
  logic loopback = 1'b1;
  logic drvLine = 1'b1;
  logic rxLine;
  logic [7:0] rxData;
  logic rxValid, rxParityErr, rxFrameErr;

  int vecs = 0;
  int errs = 0;
  int gotCnt = 0;
  logic [7:0] gotData = '0;
  logic gotPe = 1'b0;
  logic gotFe = 1'b0;

  assign rxLine = loopback ? txLine : drvLine;

  always #2.5 clk = ~clk;

  cfg_uart i_cfg_uart (
    .clk(clk), .rstN(rstN), .setupWord(setupWord), .txData(txData), .txValid(txValid),
    .txReady(txReady), .txLine(txLine), .rxLine(rxLine), .rxData(rxData), .rxValid(rxValid),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr)
  );

  always @(negedge clk) begin
    if (rstN && rxValid) begin
      gotCnt = gotCnt + 1;
      gotData = rxData;
      gotPe = rxParityErr;
      gotFe = rxFrameErr;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: %s got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // pm: 0 none, 1 fixed space, 2 fixed mark, 3 odd, 4 even
  function automatic logic [30:0] mkSetup(input int div, input int lc, input int ts, input int pm, input bit nofc);
    logic [30:0] w;
    w = '0;
    w[23:0] = div[23:0];
    w[29:28] = lc[1:0];
    w[27] = ts[0];
    w[26] = (pm != 0);
    w[25] = (pm == 1 || pm == 2);
    w[24] = (pm == 2 || pm == 4);
    w[30] = nofc;
    return w;
  endfunction

  task automatic build(input logic [7:0] d, input int lc, input int ts, input int pm,
                       input bit flipPar, input int badStop, output logic [15:0] bits, output int nb);
    int len;
    bit xr;
    bit pb;
    len = 8 - lc;
    xr = 1'b0;
    bits = '0;
    nb = 1;
    for (int i = 0; i < len; i++) begin
      bits[nb] = d[i];
      xr = xr ^ d[i];
      nb++;
    end
    if (pm != 0) begin
      if (pm == 1) pb = 1'b0;
      else if (pm == 2) pb = 1'b1;
      else if (pm == 4) pb = xr;
      else pb = ~xr;
      bits[nb] = pb ^ flipPar;
      nb++;
    end
    bits[nb] = (badStop != 0); nb++;
    if (ts != 0) begin
      bits[nb] = (badStop != 1); nb++;
    end
  endtask

  task automatic sendTx(input logic [7:0] d, input int div, input int lc, input int ts, input int pm,
                        input bit nofc, input bit doAlt, input logic [30:0] alt);
    logic [15:0] bits;
    int nb;
    int prev;
    int k;
    string tag;
    logic [7:0] mask;
    build(d, lc, ts, pm, 1'b0, -1, bits, nb);
    mask = 8'hFF >> lc;
    prev = gotCnt;
    loopback = 1'b1;
    @(negedge clk);
    setupWord = mkSetup(div, lc, ts, pm, nofc);
    txData = d;
    txValid = 1'b1;
    @(posedge clk);
    for (int n = 0; n <= nb * div; n++) begin
      @(negedge clk);
      if (n == 0) txValid = 1'b0;
      if (doAlt && n == div + 1) setupWord = alt;
      if (n < nb * div) begin
        k = n / div;
        if (doAlt) tag = "R11";
        else if (nofc) tag = "R12";
        else if (k == 0) tag = "R2";
        else if (k <= 8 - lc) tag = "R3";
        else if (pm != 0 && k == 9 - lc) tag = "R4";
        else tag = "R5";
        chk(tag, "txLine", {31'b0, txLine}, {31'b0, bits[k]});
      end
      if (n == 0) chk("R6", "txReady during frame", {31'b0, txReady}, 32'd0);
      if (n == nb * div - 1) chk("R5", "txReady last cycle", {31'b0, txReady}, 32'd0);
      if (n == nb * div) chk("R5", "txReady after frame", {31'b0, txReady}, 32'd1);
    end
    repeat (2 * div + 4) @(negedge clk);
    chk(doAlt ? "R11" : "R7", "rx count", gotCnt, prev + 1);
    chk(doAlt ? "R11" : "R7", "rxData", {24'b0, gotData}, {24'b0, d & mask});
    chk("R8", "rxParityErr", {31'b0, gotPe}, 32'd0);
    chk("R9", "rxFrameErr", {31'b0, gotFe}, 32'd0);
  endtask

  task automatic rxFrame(input logic [15:0] bits, input int nb, input int div);
    loopback = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      drvLine = bits[i];
      repeat (div - 1) @(negedge clk);
    end
    @(negedge clk);
    drvLine = 1'b1;
    repeat (2 * div + 4) @(negedge clk);
  endtask

  task automatic rxCase(input string req, input logic [7:0] d, input int div, input int lc, input int ts,
                        input int pm, input bit flipPar, input int badStop, input bit expPe, input bit expFe);
    logic [15:0] bits;
    int nb;
    int prev;
    setupWord = mkSetup(div, lc, ts, pm, 1'b0);
    repeat (4) @(negedge clk);
    build(d, lc, ts, pm, flipPar, badStop, bits, nb);
    prev = gotCnt;
    rxFrame(bits, nb, div);
    chk(req, "rx count", gotCnt, prev + 1);
    chk(req, "rxData", {24'b0, gotData}, {24'b0, d & (8'hFF >> lc)});
    chk(req, "rxParityErr", {31'b0, gotPe}, {31'b0, expPe});
    chk(req, "rxFrameErr", {31'b0, gotFe}, {31'b0, expFe});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int div;
    int prev;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R1", "txLine in reset", {31'b0, txLine}, 32'd1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "txLine idle", {31'b0, txLine}, 32'd1);
    chk("R1", "txReady idle", {31'b0, txReady}, 32'd1);
    chk("R1", "rxValid idle", {31'b0, rxValid}, 32'd0);
    chk("R1", "rx count idle", gotCnt, 0);

    // sweep: all lengths, stop settings and parity modes (R2 R3 R4 R5 R7 R12)
    for (int lc = 0; lc < 4; lc++)
      for (int ts = 0; ts < 2; ts++)
        for (int pm = 0; pm < 5; pm++)
          for (int b = 0; b < 3; b++) begin
            div = 4 + ((lc + ts + pm) % 3);
            if (b == 0) d = 8'hA5;
            else if (b == 1) d = 8'h3C ^ 8'(pm * 17 + lc);
            else d = 8'(lc * 53 + ts * 29 + pm * 11 + 1);
            sendTx(d, div, lc, ts, pm, b == 2, 1'b0, '0);
          end

    // R11: change setup mid character, then use it for the next one
    sendTx(8'h5A, 4, 0, 0, 0, 1'b0, 1'b1, mkSetup(6, 3, 1, 4, 1'b0));
    sendTx(8'h1F, 6, 3, 1, 4, 1'b0, 1'b0, '0);

    // R8: wrong computed parity and wrong fixed parity
    rxCase("R8", 8'h03, 4, 0, 0, 4, 1'b1, -1, 1'b1, 1'b0);
    rxCase("R8", 8'h2B, 5, 2, 0, 2, 1'b1, -1, 1'b1, 1'b0);
    rxCase("R8", 8'h2B, 5, 1, 1, 3, 1'b0, -1, 1'b0, 1'b0);
    // R9: first stop low, and second of two stops low
    rxCase("R9", 8'hC3, 4, 0, 0, 0, 1'b0, 0, 1'b0, 1'b1);
    rxCase("R9", 8'h55, 5, 1, 1, 3, 1'b0, 1, 1'b0, 1'b1);

    // R10: one-cycle low glitch is not a start bit
    setupWord = mkSetup(6, 0, 0, 0, 1'b0);
    loopback = 1'b0;
    repeat (4) @(negedge clk);
    prev = gotCnt;
    drvLine = 1'b0;
    @(negedge clk);
    drvLine = 1'b1;
    repeat (30) @(negedge clk);
    chk("R10", "rx count after glitch", gotCnt, prev);
    rxCase("R10", 8'h96, 6, 0, 0, 0, 1'b0, -1, 1'b0, 1'b0);

    loopback = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule